// File: doc/BRIEF.md
# Addressed Remote I/O Node Core

This block is the digital core of one node on a shared two-wire serial line. Upstream logic has already turned the line voltages into a recovered bit clock and a data bit, and the block sees both as plain inputs sampled by its own system clock. It watches the bit stream for a synchronization pattern. It then splits the stream into 10-bit words and acts on the words that carry its strapped 5-bit address.

A write word updates two output latches. A read word makes the node answer in the last three bit slots of that word. The controller holds the line high in those slots, and the node pulls the line low in each slot where it sends a 0. A sticky parity-fault flag records a bad parity seen on a word for this node. While the flag is set, writes are refused and reads get an all-ones reply. A read with good address parity clears the flag, so the controller can spot the fault and recover.

Top module: `rio_node`

## Requirements
- R1: While reset is held, and after it, `out0_o`, `out1_o` and `pulldown_o` are 0, and the node is not synchronized.
- R2: A run of 8 or more consecutive 1 bits followed by a 0 synchronizes the node, and the next bit is bit position 0 of a word. A run of only 7 ones followed by a 0 does not synchronize, and words sent before any synchronization have no effect. A new synchronization may occur at any point and restarts the word.
- R3: Word bit positions in time order: 0..4 carry the address LSB first (position 0 is address bit 0); 5 is address parity; 6 is read/write (0 = read, 1 = write); 7 is D0; 8 is D1; 9 is data parity. Words whose address differs from `node_addr_i` change no output.
- R4: A write to this node with even parity over positions 0..5, even parity over positions 7..9 and no stored fault sets `out0_o` = D0 and `out1_o` = D1 at the end of the word. The outputs change at no other time.
- R5: A read to this node with even address parity and no stored fault replies D0 = `in0_i`, D1 = `in1_i` and parity = `in0_i` XOR `in1_i`, so the three reply bits hold an even number of 1s. The inputs are sampled when the read/write bit is received.
- R6: Odd address parity on a word carrying this node's address sets the fault. While the fault is set, writes are refused and reads reply 1, 1, 1. A read with odd address parity replies 1, 1, 1 and leaves the fault set.
- R7: A read to this node with even address parity clears the fault after its reply, so a following good write is accepted.
- R8: A write to this node with even address parity but odd data parity leaves the outputs unchanged and sets the fault.
- R9: Words for other addresses never set or clear the fault, whatever their parity.
- R10: Once synchronized, words follow back to back with no new synchronization between them.
- R11: `pulldown_o` is high only during the three reply slots of a read to this node, and only in a slot whose reply bit is 0. A slot runs from the bit-clock rising edge that ends the previous slot to the rising edge that strobes the slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| node_addr_i | input | 5 | Strapped node address |
| line_clk_i | input | 1 | Recovered bit clock, data strobed on its rising edge |
| line_data_i | input | 1 | Recovered line data |
| in0_i | input | 1 | Status input reported as D0 |
| in1_i | input | 1 | Status input reported as D1 |
| out0_o | output | 1 | Output latch updated from D0 |
| out1_o | output | 1 | Output latch updated from D1 |
| pulldown_o | output | 1 | Line pulldown enable used to send a 0 |

## Verification
The bench first sends a seven-ones lead-in and checks that the node stays deaf. A counter that is off by one would accept the write that follows. It then walks the fault flag through its full cycle: set by bad address parity, set by bad data parity, ignored for foreign addresses, kept by a read with bad address parity, and cleared by a good read. A design that cleared the fault on the wrong word, or let a write through while the fault was set, would leave the output latches wrong at the next check. Read replies are decoded from the wired-AND line, and the pulldown is compared on every clock. A reply shifted by one slot, or a pulldown held past the parity slot, shows up as a mismatch.

// File: rtl/rio_pkg.sv
package rio_pkg;
  // reply bits, [0] goes out first
  typedef logic [2:0] reply_t;

  function automatic reply_t mk_reply(input logic s0, input logic s1);
    return {s0 ^ s1, s1, s0};
  endfunction
endpackage

// File: rtl/rio_sync_det.sv
module rio_sync_det #(
  parameter int unsigned SYNC_ONES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic bit_i,
  output logic sync_o
);
  localparam int unsigned CNT_W = $clog2(SYNC_ONES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SYNC_ONES);

  logic [CNT_W-1:0] ones_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ones_q <= '0;
    else if (strobe_i) begin
      if (!bit_i)                ones_q <= '0;
      else if (ones_q != CNT_MAX) ones_q <= ones_q + 1'b1;
    end
  end

  assign sync_o = strobe_i && !bit_i && (ones_q == CNT_MAX);
endmodule

// File: rtl/rio_word_rx.sv
module rio_word_rx #(
  parameter int unsigned WORD_LEN = 10,
  parameter int unsigned POS_W    = $clog2(WORD_LEN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  logic                bit_i,
  input  logic                sync_i,
  output logic                evt_o,
  output logic [POS_W-1:0]    pos_o,
  output logic [WORD_LEN-2:0] word_o
);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(WORD_LEN - 1);

  logic                active_q;
  logic [POS_W-1:0]    pos_q;
  logic [WORD_LEN-2:0] word_q;

  assign evt_o  = strobe_i && active_q && !sync_i;
  assign pos_o  = pos_q;
  assign word_o = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      word_q   <= '0;
    end else if (sync_i) begin
      active_q <= 1'b1;
      pos_q    <= '0;
    end else if (evt_o) begin
      if (pos_q != POS_LAST) begin
        word_q[pos_q] <= bit_i;
        pos_q         <= pos_q + 1'b1;
      end else begin
        pos_q <= '0;
      end
    end
  end

  AST_SYNC_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (active_q && pos_q == '0)); // R2
endmodule

// File: rtl/rio_node_ctl.sv
module rio_node_ctl
  import rio_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned POS_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              bit_i,
  input  logic              sync_i,
  input  logic [ADDR_W+3:0] word_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  input  logic              in0_i,
  input  logic              in1_i,
  output logic              out0_o,
  output logic              out1_o,
  output logic              pulldown_o
);
  localparam int unsigned P_RW   = ADDR_W + 1;
  localparam int unsigned P_D0   = ADDR_W + 2;
  localparam int unsigned P_D1   = ADDR_W + 3;
  localparam int unsigned P_DPAR = ADDR_W + 4;

  logic   fault_q, reply_act_q, out0_q, out1_q;
  reply_t reply_q;

  logic addr_hit, apar_ok, dpar_ok, at_rw, at_data, at_end, read_hit, write_ok;

  assign addr_hit = (word_i[ADDR_W-1:0] == node_addr_i);
  assign apar_ok  = ~^word_i[ADDR_W:0];
  assign dpar_ok  = ~^{word_i[P_D1], word_i[P_D0], bit_i};
  assign at_rw    = evt_i && (pos_i == POS_W'(P_RW));
  assign at_data  = evt_i && (pos_i == POS_W'(P_D0) || pos_i == POS_W'(P_D1));
  assign at_end   = evt_i && (pos_i == POS_W'(P_DPAR));
  assign read_hit = at_rw && addr_hit && !bit_i;
  assign write_ok = at_end && addr_hit && word_i[P_RW] && apar_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q     <= 1'b0;
      reply_act_q <= 1'b0;
      reply_q     <= '1;
      out0_q      <= 1'b0;
      out1_q      <= 1'b0;
    end else begin
      // reply path
      if (sync_i) begin
        reply_act_q <= 1'b0;
      end else if (read_hit) begin
        reply_act_q <= 1'b1;
        reply_q     <= (fault_q || !apar_ok) ? '1 : mk_reply(in0_i, in1_i);
      end else if (at_data && reply_act_q) begin
        reply_q <= {1'b1, reply_q[2:1]};
      end else if (at_end) begin
        reply_act_q <= 1'b0;
      end
      // sticky fault
      if (at_rw && addr_hit) begin
        if (!apar_ok)    fault_q <= 1'b1;
        else if (!bit_i) fault_q <= 1'b0;
      end else if (write_ok && !dpar_ok) begin
        fault_q <= 1'b1;
      end
      // output latches
      if (write_ok && dpar_ok && !fault_q) begin
        out0_q <= word_i[P_D0];
        out1_q <= word_i[P_D1];
      end
    end
  end

  assign out0_o     = out0_q;
  assign out1_o     = out1_q;
  assign pulldown_o = reply_act_q && !reply_q[0];

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_end |=> $stable({out0_q, out1_q})); // R4
  AST_FAULT_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_end && fault_q) |=> $stable({out0_q, out1_q})); // R6
  AST_FAULT_REPLY_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_hit && fault_q) |=> (reply_q == 3'b111)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_hit && apar_ok) |=> !fault_q); // R7
  AST_REPLY_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_hit && apar_ok && !fault_q) |=> !(^reply_q)); // R5
  AST_PD_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulldown_o |-> (pos_i >= POS_W'(P_D0))); // R11
endmodule

// File: rtl/rio_node.sv
module rio_node #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned SYNC_ONES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] node_addr_i,
  input  logic              line_clk_i,
  input  logic              line_data_i,
  input  logic              in0_i,
  input  logic              in1_i,
  output logic              out0_o,
  output logic              out1_o,
  output logic              pulldown_o
);
  localparam int unsigned WORD_LEN = ADDR_W + 5;
  localparam int unsigned POS_W    = $clog2(WORD_LEN);

  logic                line_clk_q, strobe, sync, evt;
  logic [POS_W-1:0]    pos;
  logic [WORD_LEN-2:0] word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_clk_q <= 1'b0;
    else         line_clk_q <= line_clk_i;
  end
  assign strobe = line_clk_i && !line_clk_q;

  rio_sync_det #(.SYNC_ONES(SYNC_ONES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe),
    .bit_i   (line_data_i),
    .sync_o  (sync)
  );

  rio_word_rx #(.WORD_LEN(WORD_LEN), .POS_W(POS_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe),
    .bit_i   (line_data_i),
    .sync_i  (sync),
    .evt_o   (evt),
    .pos_o   (pos),
    .word_o  (word)
  );

  rio_node_ctl #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .pos_i      (pos),
    .bit_i      (line_data_i),
    .sync_i     (sync),
    .word_i     (word),
    .node_addr_i(node_addr_i),
    .in0_i      (in0_i),
    .in1_i      (in1_i),
    .out0_o     (out0_o),
    .out1_o     (out1_o),
    .pulldown_o (pulldown_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!out0_o && !out1_o && !pulldown_o)); // R1
endmodule

// File: tb/rio_node_bench.sv
`timescale 1ns/100ps
module rio_node_bench;
  localparam logic [4:0] NODE = 5'd24;
  localparam int PH = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic line_clk = 1'b0, ctrl = 1'b1, in0 = 1'b0, in1 = 1'b0;
  logic out0, out1, pd, line_data;
  bit   cmp_en = 1'b0;
  int   n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  assign line_data = ctrl & ~pd;   // wired-AND line

  rio_node u_rio_node (
    .clk_i(clk), .rst_ni(rst_ni), .node_addr_i(NODE),
    .line_clk_i(line_clk), .line_data_i(line_data),
    .in0_i(in0), .in1_i(in1),
    .out0_o(out0), .out1_o(out1), .pulldown_o(pd)
  );

  // behavioural reference
  int   m_ones = 0, m_idx = 0;
  bit   m_active = 0, m_fault = 0, m_out0 = 0, m_out1 = 0, m_ract = 0;
  logic [9:0] m_bits = '0;
  bit   m_reply[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_bit(input logic b);
    bit is_sync, hit, aok, dok;
    is_sync = 0;
    if (b) m_ones++;
    else begin is_sync = (m_ones >= 8); m_ones = 0; end
    if (is_sync) begin
      m_active = 1; m_idx = 0; m_ract = 0; m_reply.delete();
    end else if (m_active) begin
      m_bits[m_idx] = b;
      hit = (m_bits[4:0] == NODE);
      aok = ((^m_bits[5:0]) == 1'b0);
      if (m_idx == 6 && hit) begin
        if (!aok) m_fault = 1;
        if (b == 1'b0) begin
          m_ract = 1; m_reply.delete();
          if (m_fault) begin m_reply.push_back(1); m_reply.push_back(1); m_reply.push_back(1); end
          else begin m_reply.push_back(in0); m_reply.push_back(in1); m_reply.push_back(in0 ^ in1); end
          if (aok) m_fault = 0;
        end
      end else if ((m_idx == 7 || m_idx == 8) && m_ract) begin
        void'(m_reply.pop_front());
      end else if (m_idx == 9) begin
        m_ract = 0; m_reply.delete();
        if (hit && m_bits[6]) begin
          dok = ((m_bits[7] ^ m_bits[8] ^ b) == 1'b0);
          if (aok && dok && !m_fault) begin m_out0 = m_bits[7]; m_out1 = m_bits[8]; end
          if (aok && !dok) m_fault = 1;
        end
      end
      m_idx = (m_idx + 1) % 10;
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (cmp_en) begin
      bit epd;
      epd = m_ract && (m_reply.size() > 0) && !m_reply[0];
      chk(out0 == m_out0, "R4 out0 vs model", out0, m_out0);
      chk(out1 == m_out1, "R4 out1 vs model", out1, m_out1);
      chk(pd == epd, "R11 pulldown vs model", pd, epd);
    end
  end

  task automatic send_bit(input logic b, output logic lv);
    ctrl = b;
    repeat (PH) @(posedge clk); #1;
    lv = line_data;
    cmp_en = 0;
    line_clk = 1'b1;
    repeat (PH) @(posedge clk); #1;
    model_bit(lv);
    line_clk = 1'b0;
    @(posedge clk); #1;
    cmp_en = 1;
  endtask

  task automatic send_sync(input int ones);
    logic lv;
    send_bit(1'b0, lv);
    for (int i = 0; i < ones; i++) send_bit(1'b1, lv);
    send_bit(1'b0, lv);
  endtask

  task automatic send_word(input logic [4:0] a, input logic rw, input logic d0, input logic d1,
                           input logic fa, input logic fd, output logic [2:0] r);
    logic lv;
    for (int i = 0; i < 5; i++) send_bit(a[i], lv);
    send_bit((^a) ^ fa, lv);
    send_bit(rw, lv);
    if (rw) begin
      send_bit(d0, lv); send_bit(d1, lv); send_bit(d0 ^ d1 ^ fd, lv);
      r = '1;
    end else begin
      send_bit(1'b1, lv); r[0] = lv;
      send_bit(1'b1, lv); r[1] = lv;
      send_bit(1'b1, lv); r[2] = lv;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic d0, input logic d1, input logic fa, input logic fd);
    logic [2:0] r;
    send_word(a, 1'b1, d0, d1, fa, fd, r);
  endtask

  task automatic rd(input logic [4:0] a, input logic fa, input logic i0, input logic i1,
                    input logic [2:0] exp, input string tag);
    logic [2:0] r;
    in0 = i0; in1 = i1;
    send_word(a, 1'b0, 1'b1, 1'b1, fa, 1'b0, r);
    chk(r == exp, tag, r, exp);
  endtask

  task automatic outs(input logic e0, input logic e1, input string tag);
    chk({out0, out1} == {e0, e1}, tag, {out0, out1}, {e0, e1});
  endtask

  initial begin
    repeat (5) @(posedge clk); #1;
    chk({out0, out1, pd} == 3'b000, "R1 state during reset", {out0, out1, pd}, 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    cmp_en = 1;
    outs(0, 0, "R1 outputs after reset");

    send_sync(7);                         // too short
    wr(NODE, 1, 1, 0, 0);
    outs(0, 0, "R2 seven ones do not sync");

    send_sync(8);
    wr(NODE, 1, 0, 0, 0);
    outs(1, 0, "R4 write accepted after sync");
    wr(5'd5, 0, 1, 0, 0);
    outs(1, 0, "R3 foreign address ignored");
    wr(NODE, 0, 1, 0, 0);
    outs(0, 1, "R10 back-to-back write");

    rd(NODE, 0, 1, 0, 3'b101, "R5 read in0=1 in1=0");
    rd(NODE, 0, 0, 1, 3'b110, "R5 read in0=0 in1=1");
    rd(NODE, 0, 0, 0, 3'b000, "R5 read in0=0 in1=0");
    rd(NODE, 0, 1, 1, 3'b011, "R5 read in0=1 in1=1");

    wr(NODE, 1, 1, 1, 0);
    outs(0, 1, "R6 bad address parity write refused");
    wr(NODE, 1, 1, 0, 0);
    outs(0, 1, "R6 write refused while fault set");
    rd(NODE, 0, 1, 0, 3'b111, "R6 fault read replies ones");
    wr(NODE, 1, 1, 0, 0);
    outs(1, 1, "R7 good read cleared fault");

    wr(NODE, 0, 0, 0, 1);
    outs(1, 1, "R8 bad data parity write refused");
    rd(NODE, 0, 0, 0, 3'b111, "R8 bad data parity set fault");
    wr(NODE, 0, 0, 0, 0);
    outs(0, 0, "R7 write after clearing read");

    wr(5'd7, 1, 1, 1, 0);
    rd(5'd9, 1, 0, 0, 3'b111, "R9 foreign read leaves line alone");
    wr(NODE, 1, 0, 0, 0);
    outs(1, 0, "R9 foreign bad parity did not set fault");

    rd(NODE, 1, 0, 0, 3'b111, "R6 bad parity read replies ones");
    wr(NODE, 0, 1, 0, 0);
    outs(1, 0, "R6 bad parity read keeps fault");
    rd(NODE, 0, 0, 0, 3'b111, "R7 good read after fault");
    wr(NODE, 0, 1, 0, 0);
    outs(0, 1, "R7 fault cleared");

    send_sync(10);
    wr(NODE, 1, 1, 0, 0);
    outs(1, 1, "R2 resync then write");

    cmp_en = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..all actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule